// File: doc/BRIEF.md
# Fractional Microsecond Time Base

This block keeps a free-running microsecond count from a reference clock whose frequency need not be a whole number of megahertz. A rational prescaler holds two 8-bit fields, each stored as its value minus one: a cycle count M and a tick count K. Every K ticks are spread over M reference cycles, so the count advances at exactly 1 MHz on average once the two fields match the reference clock (for example 64 cycles to 5 ticks at 12.8 MHz, or 12 cycles to 1 tick at 12 MHz).

A small register port holds the ratio and returns the count. Reads are combinational from the address. Writes take effect on the clock edge. A one-cycle `tick_1us` pulse comes with every increment of the count, so other timers can share the same time base without reading the count.

The prescaler works as an accumulator. Each reference cycle adds K to it. When the sum reaches M, M is subtracted and one tick is emitted. Writing the ratio clears the accumulator but leaves the count as it is.

Top module: `usec_timebase`

## Requirements
- R1: After reset the ratio register reads 0x0000000B, the count reads 0 and `tick_1us` is low.
- R2: The ratio register is at offset 0x14 and is written and read there. Bits 7:0 hold cycles-minus-one and bits 15:8 hold ticks-minus-one. Read bits 31:16 are zero.
- R3: The count is read at offset 0x10 and is zero-extended to 32 bits. It is CNT_W bits wide, with a default of 32, and it only counts upward.
- R4: Over N reference cycles after a ratio write, with ticks field T and cycles field C where T <= C, the count advances by exactly floor(N*(T+1)/(C+1)).
- R5: The first tick after a ratio write falls on the reference edge at which the running sum k*(T+1) first reaches C+1. For ratio 0x000B that is the 12th edge after the write edge.
- R6: A ratio write clears the accumulator. It does not change the count, and no tick is emitted on the write edge.
- R7: `tick_1us` is high for exactly the cycles in which the count has just increased by one. The count holds in every other cycle.
- R8: The count wraps from all ones to zero.
- R9: Reads at offset 0x4c (reserved) and at every unmapped offset return zero. Writes to 0x4c, 0x10 or any offset other than 0x14 change neither the ratio nor the count.
- R10: When T > C the block ticks on every reference edge, and the accumulator stays below C+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 16 | Write data; only the ratio register is writable |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick_1us | output | 1 | One-cycle pulse with each count increment |

## Verification
The ratio is tried at each integer divide used for common crystals: 12, 13, 26 and 48 cycles per tick. It is also tried at the four fractional five-tick ratios, over whole ratio periods. A correct tick total in these windows separates an exact rational accumulator from a truncating integer divider.

A window that stops partway through a period (4 cycles to 3 ticks) checks the floor behaviour and the remainder carried between ticks. Ratios with more ticks than cycles exercise the clamping path.

Edge-exact probes test several timing points: where the first tick falls after a write, suppression of the tick on the write edge, and the wrap on a narrow counter.

// File: rtl/usec_tb_pkg.sv
package usec_tb_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam int MOD_W   = FIELD_W + 1;
  localparam int SUM_W   = FIELD_W + 2;

  localparam logic [7:0] OFF_COUNT  = 8'h10;
  localparam logic [7:0] OFF_RATIO  = 8'h14;
  localparam logic [7:0] OFF_HOLD   = 8'h4c;
  localparam logic [CFG_W-1:0] RATIO_RESET = 16'h000b;

  typedef struct packed {
    logic [FIELD_W-1:0] ticks_m1;
    logic [FIELD_W-1:0] cycles_m1;
  } ratio_t;

  function automatic logic [MOD_W-1:0] ratio_step(input ratio_t r);
    return MOD_W'(r.ticks_m1) + MOD_W'(1);
  endfunction

  function automatic logic [MOD_W-1:0] ratio_mod(input ratio_t r);
    return MOD_W'(r.cycles_m1) + MOD_W'(1);
  endfunction

  // Next accumulator value; the remainder is clamped below the modulus.
  function automatic logic [MOD_W-1:0] acc_next(input logic [MOD_W-1:0] acc,
                                                input logic [MOD_W-1:0] step,
                                                input logic [MOD_W-1:0] modv);
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;
    sum = SUM_W'(acc) + SUM_W'(step);
    rem = sum - SUM_W'(modv);
    if (sum < SUM_W'(modv))      return MOD_W'(sum);
    else if (rem >= SUM_W'(modv)) return modv - MOD_W'(1);
    else                          return MOD_W'(rem);
  endfunction

  function automatic logic acc_hit(input logic [MOD_W-1:0] acc,
                                   input logic [MOD_W-1:0] step,
                                   input logic [MOD_W-1:0] modv);
    return (SUM_W'(acc) + SUM_W'(step)) >= SUM_W'(modv);
  endfunction
endpackage

// File: rtl/usec_ratio_regs.sv
module usec_ratio_regs
  import usec_tb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CFG_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]  count,
  output ratio_t            ratio,
  output logic              ratio_wr,
  output logic [DATA_W-1:0] reg_rdata
);
  logic sel_count;
  logic sel_ratio;

  assign sel_count = (reg_addr == ADDR_W'(OFF_COUNT));
  assign sel_ratio = (reg_addr == ADDR_W'(OFF_RATIO));
  assign ratio_wr  = reg_wr && sel_ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ratio <= ratio_t'(RATIO_RESET);
    else if (ratio_wr) ratio <= ratio_t'(reg_wdata);
  end

  // The reserved hold offset and all unmapped offsets fall to zero.
  always_comb begin
    reg_rdata = '0;
    if (sel_count)      reg_rdata[CNT_W-1:0] = count;
    else if (sel_ratio) reg_rdata[CFG_W-1:0] = ratio;
  end
endmodule

// File: rtl/usec_frac_prescaler.sv
module usec_frac_prescaler
  import usec_tb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ratio_t           ratio,
  input  logic             clear,
  output logic             advance,
  output logic [MOD_W-1:0] acc,
  output logic [MOD_W-1:0] modulus
);
  logic [MOD_W-1:0] step;

  assign step    = ratio_step(ratio);
  assign modulus = ratio_mod(ratio);
  assign advance = !clear && acc_hit(acc, step, modulus);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc <= '0;
    else if (clear) acc <= '0;
    else            acc <= acc_next(acc, step, modulus);
  end
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= advance;
      if (advance) count <= count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_tb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_1us
);
  ratio_t           ratio_q;
  logic             ratio_wr_evt;
  logic             advance_evt;
  logic [MOD_W-1:0] acc_val;
  logic [MOD_W-1:0] mod_val;
  logic [CNT_W-1:0] cnt_val;

  usec_ratio_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .count(cnt_val), .ratio(ratio_q),
    .ratio_wr(ratio_wr_evt), .reg_rdata(reg_rdata)
  );

  usec_frac_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .ratio(ratio_q), .clear(ratio_wr_evt),
    .advance(advance_evt), .acc(acc_val), .modulus(mod_val)
  );

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .advance(advance_evt),
    .count(cnt_val), .tick(tick_1us)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk
  import usec_tb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              tick_1us,
  input logic              ratio_wr_evt,
  input logic [CFG_W-1:0]  ratio_q,
  input logic [MOD_W-1:0]  acc_val,
  input logic [MOD_W-1:0]  mod_val,
  input logic [CNT_W-1:0]  cnt_val
);
  AST_TICK_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1us |-> cnt_val == $past(cnt_val) + CNT_W'(1)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1us |-> $stable(cnt_val)); // R7
  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    acc_val < mod_val); // R10
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr_evt |=> (!tick_1us && acc_val == '0)); // R6
  AST_RATIO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_wr_evt |=> $stable(ratio_q)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(OFF_COUNT) && reg_addr != ADDR_W'(OFF_RATIO)) |-> reg_rdata == '0); // R9
  AST_RATIO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFF_RATIO) && !reg_wr) |-> reg_rdata[DATA_W-1:CFG_W] == '0); // R2
endmodule

bind usec_timebase usec_timebase_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .tick_1us(tick_1us), .ratio_wr_evt(ratio_wr_evt),
  .ratio_q(ratio_q), .acc_val(acc_val), .mod_val(mod_val), .cnt_val(cnt_val)
);

// File: tb/usec_timebase_bench.sv
module usec_timebase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {ratio, cycles in window, expected ticks}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h000b, 16'd120, 16'd10},
    {16'h000c, 16'd130, 16'd10},
    {16'h0019, 16'd260, 16'd10},
    {16'h002f, 16'd480, 16'd10},
    {16'h043f, 16'd640, 16'd50},
    {16'h0453, 16'd336, 16'd20},
    {16'h045f, 16'd288, 16'd15},
    {16'h04bf, 16'd384, 16'd10},
    {16'h0203, 16'd10,  16'd7},
    {16'h0500, 16'd50,  16'd50},
    {16'h0000, 16'd17,  16'd17}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick;
  logic [7:0]  n_addr = '0;
  logic        n_wr = 1'b0;
  logic [15:0] n_wdata = '0;
  logic [31:0] n_rdata;
  logic        n_tick;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usec_timebase u_usec_timebase (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .tick_1us(tick)
  );

  usec_timebase #(.CNT_W(8)) u_usec_timebase_narrow (
    .clk(clk), .rst_n(rst_n), .reg_addr(n_addr), .reg_wr(n_wr),
    .reg_wdata(n_wdata), .reg_rdata(n_rdata), .tick_1us(n_tick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wrt(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; addr = 8'h10;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, c0, c1;
    int nt;
    #(CLK_PERIOD * 3 + 2);
    // R1 reset state
    rd(8'h14, d); check("R1 ratio reset", d, 32'h0000_000b);
    rd(8'h10, d); check("R1 count reset", d, 32'h0);
    check("R1 tick reset", {31'b0, tick}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R5 first tick on 12th edge after write
    wrt(8'h14, 16'h000b);
    rd(8'h10, c0);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i == 11) check("R5 no tick before edge 12", {31'b0, tick}, 32'h0);
      if (i == 12) check("R5 tick on edge 12", {31'b0, tick}, 32'h1);
      if (i == 13) check("R7 pulse one cycle", {31'b0, tick}, 32'h0);
    end
    rd(8'h10, d); check("R3 count after first tick", d, c0 + 1);

    // R2 read back of ratio register
    wrt(8'h14, 16'h1234);
    rd(8'h14, d); check("R2 ratio readback", d, 32'h0000_1234);

    // R4 / R7 vector table
    for (int v = 0; v < NVEC; v++) begin
      wrt(8'h14, VEC[v][47:32]);
      rd(8'h10, c0);
      nt = 0;
      for (int i = 0; i < int'(VEC[v][31:16]); i++) begin
        @(negedge clk);
        if (tick) nt++;
      end
      rd(8'h10, c1);
      check("R4 ticks over window", c1 - c0, {16'h0, VEC[v][15:0]});
      check("R7 pulses match increments", nt, c1 - c0);
    end

    // R10 ticks every edge with ticks field above cycles field
    wrt(8'h14, 16'hff00);
    rd(8'h10, c0);
    @(negedge clk);
    check("R10 tick on edge", {31'b0, tick}, 32'h1);
    @(negedge clk);
    rd(8'h10, c1); check("R10 two ticks", c1 - c0, 32'd2);

    // R6 write keeps count, suppresses tick on write edge
    wrt(8'h14, 16'h0000);
    @(negedge clk);
    rd(8'h10, c0);
    wrt(8'h14, 16'h0001);
    check("R6 no tick on write edge", {31'b0, tick}, 32'h0);
    rd(8'h10, d); check("R6 count kept", d, c0 + 1);
    wrt(8'h14, 16'h0000);

    // R9 reserved and unmapped offsets
    rd(8'h4c, d); check("R9 hold offset reads zero", d, 32'h0);
    rd(8'h20, d); check("R9 unmapped reads zero", d, 32'h0);
    wrt(8'h4c, 16'h00ff);
    rd(8'h14, d); check("R9 hold write ignored", d, 32'h0);
    rd(8'h10, c0);
    wrt(8'h10, 16'hbeef);
    rd(8'h10, d); check("R9 count write ignored", d, c0 + 2);
    rd(8'h14, d); check("R9 ratio kept", d, 32'h0);

    // R8 wrap on narrow instance (tick every edge)
    @(negedge clk);
    n_addr = 8'h14; n_wdata = 16'h0000; n_wr = 1'b1;
    @(negedge clk);
    n_wr = 1'b0; n_addr = 8'h10;
    #1; c0 = n_rdata;
    for (int i = 0; i < 256 - int'(c0); i++) @(negedge clk);
    #1; check("R8 wrap to zero", n_rdata, 32'h0);
    @(negedge clk);
    #1; check("R8 counts on after wrap", n_rdata, 32'h1);

    finish_run();
  end
endmodule